// File: doc/BRIEF.md
# Double-Buffered Byte-to-Serial Loader

This block takes bytes that a host processor writes over a parallel bus and turns them into a serial bit stream for a configuration target. A write is recognised when three select inputs and a write strobe are all high together. The block acts when that combined strobe ends. The combined strobe is synchronised into the serial clock domain first. The byte is then placed in a holding register. From there it passes to a shift register, which presents the bits on a serial data output, least-significant bit first, one bit per serial clock period.

A ready output gives the host its handshake. Ready drops as soon as a byte is accepted. It comes back once the holding register has handed its byte to the shifter. If the shifter is idle, that takes two periods. If the shifter is still working, ready stays low until the shifter's last bit period has ended. A byte written with the last-byte flag set is shifted for only seven bits. After that the block freezes: the serial clock output is parked high, the data output keeps bit 6 of that byte, and a done flag is raised.

Top module: `byte_serial_loader`

## Requirements
- R1: A write is the falling edge of `sel_a_i & sel_b_i & sel_c_i & wr_i`, seen through a two-flop synchroniser. `data_i` and `last_i` are taken on the third rising `clk_i` edge after that AND goes low, so the host must hold them stable until then.
- R2: `rdy_o` goes low on the same edge that accepts a byte.
- R3: If the shift register is idle when a byte is accepted, `rdy_o` stays low for exactly two clock periods. It rises on the edge that puts bit 0 of that byte on `sdat_o`.
- R4: If the shift register is still working, the held byte enters it on the edge that ends the current byte's final bit period, so no gap appears in the stream. `rdy_o` rises on that same edge and is never low for more than nine periods in a row.
- R5: Bits leave least-significant bit first, one per clock period, and change on the rising edge. If a normal byte ends with nothing waiting behind it, `sdat_o` keeps showing bit 7.
- R6: A byte taken with `last_i` high presents only bits 0 to 6. On the edge after bit 6, `done_o` goes high. From then on, `sdat_o` holds bit 6 and `sclk_o` stays high.
- R7: Until `done_o` is high, `sclk_o` follows `clk_i`.
- R8: A write that ends while `rdy_o` is low, including one that falls on the transfer edge itself, is dropped. It sets `overrun_o`, which stays high until reset.
- R9: Once a last byte has been accepted, any write made while `rdy_o` is high is ignored. `rdy_o`, `sdat_o` and `overrun_o` do not change.
- R10: While `rst_i` is high, `rdy_o` = 1, `sdat_o` = 0, `done_o` = 0 and `overrun_o` = 0. Both registers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial (configuration) clock; all state runs on its rising edge |
| rst_i | input | 1 | Asynchronous active-high reset |
| sel_a_i | input | 1 | First select qualifier, active high |
| sel_b_i | input | 1 | Second select qualifier, active high |
| sel_c_i | input | 1 | Third select qualifier, active high |
| wr_i | input | 1 | Host write strobe, active high |
| data_i | input | DATA_W | Byte written by the host |
| last_i | input | 1 | Marks the byte being written as the final one |
| rdy_o | output | 1 | High when the holding register can take a byte |
| sdat_o | output | 1 | Serial data, LSB first |
| sclk_o | output | 1 | Serial clock to the target; parked high after the final byte |
| done_o | output | 1 | Final byte finished |
| overrun_o | output | 1 | Sticky: a write arrived while busy |

## Verification
Two events can land on the same clock edge: the holding register handing its byte to the shifter, and a new host write completing. On that edge the new write must be counted as an overrun, because the register still holds data before the edge. It must not be taken into the register that is just being emptied. The bench sets this up with three back-to-back writes. The third write is timed so that its capture edge is exactly the transfer edge of the second. The bench then judges four things: the second byte follows the first with no gap, `overrun_o` rises in that very sample, `rdy_o` comes back high, and the stream ends holding the second byte's bit 7 with the third byte never appearing.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  // Number of bit periods a byte occupies in the shifter.
  function automatic int unsigned burst_len(input logic is_last, input int unsigned width);
    return is_last ? width - 1 : width;
  endfunction

  // Trailing edge of a level: was high, now low.
  function automatic logic trailing(input logic older, input logic newer);
    return older & ~newer;
  endfunction

endpackage

// File: rtl/bsl_strobe_sync.sv
module bsl_strobe_sync
  import bsl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic sel_c_i,
  input  logic wr_i,
  output logic fall_o
);

  logic sel_all;
  logic [STAGES:0] chain;

  assign sel_all = sel_a_i & sel_b_i & sel_c_i & wr_i;

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its history
  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
          chain[g] <= 1'b0;
        end else if (g == 0) begin
          chain[g] <= sel_all;
        end else begin
          chain[g] <= chain[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign fall_o = trailing(chain[STAGES], chain[STAGES-1]);

endmodule

// File: rtl/bsl_hold.sv
module bsl_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              capture_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              full_o,
  output logic              ripe_o
);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      data_o <= '0;
      last_o <= 1'b0;
      full_o <= 1'b0;
      ripe_o <= 1'b0;
    end else begin
      // a byte must sit one full period before it may leave
      ripe_o <= full_o & ~take_i;
      if (take_i) begin
        full_o <= 1'b0;
      end else if (capture_i) begin
        full_o <= 1'b1;
        data_o <= data_i;
        last_o <= last_i;
      end
    end
  end

endmodule

// File: rtl/bsl_shift.sv
module bsl_shift
  import bsl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  output logic              sdat_o,
  output logic              room_o,
  output logic              closing_o,
  output logic              done_o
);

  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sreg;
  logic [CW-1:0]     left;
  logic              last_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      sreg   <= '0;
      left   <= '0;
      last_q <= 1'b0;
      done_o <= 1'b0;
    end else if (load_i) begin
      sreg   <= data_i;
      left   <= CW'(burst_len(last_i, DATA_W));
      last_q <= last_i;
    end else if (left > CW'(1)) begin
      sreg <= sreg >> 1;
      left <= left - CW'(1);
    end else if (left == CW'(1)) begin
      left <= '0;
      if (last_q) begin
        done_o <= 1'b1;
      end
    end
  end

  assign sdat_o    = sreg[0];
  assign room_o    = (left <= CW'(1)) & ~done_o;
  assign closing_o = done_o | (last_q & (left != '0));

endmodule

// File: rtl/byte_serial_loader.sv
module byte_serial_loader #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              sel_c_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  output logic              rdy_o,
  output logic              sdat_o,
  output logic              sclk_o,
  output logic              done_o,
  output logic              overrun_o
);

  // named internal events
  logic              ev_strobe;
  logic              ev_accept;
  logic              ev_collide;
  logic              ev_take;
  logic              ev_room;
  logic              sh_closing;
  logic              hold_full;
  logic              hold_ripe;
  logic              hold_last;
  logic [DATA_W-1:0] hold_data;
  logic              refuse;

  bsl_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .sel_c_i (sel_c_i),
    .wr_i    (wr_i),
    .fall_o  (ev_strobe)
  );

  assign refuse     = sh_closing | (hold_full & hold_last);
  assign ev_accept  = ev_strobe & ~hold_full & ~refuse;
  assign ev_collide = ev_strobe & hold_full;
  assign ev_take    = hold_full & hold_ripe & ev_room;

  bsl_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (ev_accept),
    .take_i    (ev_take),
    .data_i    (data_i),
    .last_i    (last_i),
    .data_o    (hold_data),
    .last_o    (hold_last),
    .full_o    (hold_full),
    .ripe_o    (hold_ripe)
  );

  bsl_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (ev_take),
    .data_i    (hold_data),
    .last_i    (hold_last),
    .sdat_o    (sdat_o),
    .room_o    (ev_room),
    .closing_o (sh_closing),
    .done_o    (done_o)
  );

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      overrun_o <= 1'b0;
    end else if (ev_collide) begin
      overrun_o <= 1'b1;
    end
  end

  assign rdy_o  = ~hold_full;
  // done_o changes only while clk_i is high, so the OR never glitches
  assign sclk_o = clk_i | done_o;

endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
  parameter int BUSY_MAX = 9
) (
  input logic clk_i,
  input logic rst_i,
  input logic accept_i,
  input logic collide_i,
  input logic take_i,
  input logic room_i,
  input logic rdy_i,
  input logic sdat_i,
  input logic done_i,
  input logic overrun_i
);

  localparam int RW = $clog2(BUSY_MAX + 2);

  logic [RW-1:0] low_run;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      low_run <= '0;
    end else if (rdy_i) begin
      low_run <= '0;
    end else if (low_run <= RW'(BUSY_MAX)) begin
      low_run <= low_run + RW'(1);
    end
  end

  // R2
  rdy_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    accept_i |=> !rdy_i);

  // R3
  idle_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    accept_i && room_i |=> !take_i ##1 take_i);

  // R4
  rdy_return_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    take_i |=> rdy_i);

  // R4
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    low_run <= RW'(BUSY_MAX));

  // R6
  done_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_i |=> done_i && $stable(sdat_i));

  // R8
  collide_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    collide_i |=> overrun_i);

  // R8
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    overrun_i |=> overrun_i);

endmodule

bind byte_serial_loader bsl_checker #(.BUSY_MAX(9)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .accept_i  (ev_accept),
  .collide_i (ev_collide),
  .take_i    (ev_take),
  .room_i    (ev_room),
  .rdy_i     (rdy_o),
  .sdat_i    (sdat_o),
  .done_i    (done_o),
  .overrun_i (overrun_o)
);

// File: tb/byte_serial_loader_bench.sv
module byte_serial_loader_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sa = 1'b0, sb = 1'b0, sc = 1'b0, wr = 1'b0, last = 1'b0;
  logic [7:0] data = 8'h00;
  logic       rdy, sdat, sclk, done, ovr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic s_dat [0:31];
  logic s_rdy [0:31];
  logic s_done[0:31];
  logic s_clk [0:31];
  logic s_ovr [0:31];

  // each entry: byte, expected busy periods with an idle shifter
  localparam logic [11:0] VEC [0:5] = '{
    {8'hA5, 4'd2}, {8'h00, 4'd2}, {8'hFF, 4'd2},
    {8'h81, 4'd2}, {8'h3C, 4'd2}, {8'h6E, 4'd2}
  };

  always #2 clk = ~clk;

  byte_serial_loader u_byte_serial_loader (
    .clk_i(clk), .rst_i(rst), .sel_a_i(sa), .sel_b_i(sb), .sel_c_i(sc),
    .wr_i(wr), .data_i(data), .last_i(last), .rdy_o(rdy), .sdat_o(sdat),
    .sclk_o(sclk), .done_o(done), .overrun_o(ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic strobe_on(input logic [7:0] d, input logic l);
    sa = 1'b1; sb = 1'b1; sc = 1'b1; wr = 1'b1; data = d; last = l;
  endtask

  task automatic strobe_off();
    sa = 1'b0; sb = 1'b0; sc = 1'b0; wr = 1'b0;
  endtask

  // called at a falling edge; returns four falling edges later
  task automatic bus_write(input logic [7:0] d, input logic l);
    strobe_on(d, l);
    @(negedge clk);
    strobe_off();
    repeat (3) @(negedge clk);
  endtask

  // called at a falling edge; returns at the first falling edge with rdy high again
  task automatic send_and_wait(input logic [7:0] d, input logic l,
                               output int lows, output int first_low);
    lows = 0;
    first_low = -1;
    strobe_on(d, l);
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (i == 1) strobe_off();
      if (!rdy) begin
        if (lows == 0) first_low = i;
        lows++;
      end else if (lows > 0) begin
        break;
      end
    end
  endtask

  task automatic sample_run(input int n);
    for (int k = 0; k < n; k++) begin
      #1;
      s_dat[k] = sdat; s_rdy[k] = rdy; s_done[k] = done; s_clk[k] = sclk; s_ovr[k] = ovr;
      @(negedge clk);
    end
  endtask

  task automatic check_reset_state();
    #1;
    check(rdy == 1'b1, "R10 rdy", rdy, 1);
    check(sdat == 1'b0, "R10 sdat", sdat, 0);
    check(done == 1'b0, "R10 done", done, 0);
    check(ovr == 1'b0, "R10 overrun", ovr, 0);
  endtask

  initial begin
    int lows, first_low;
    logic [7:0] got, got_b, exp_b;

    repeat (3) @(negedge clk);
    check_reset_state();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // table of idle-shifter writes
    for (int v = 0; v < 6; v++) begin
      send_and_wait(VEC[v][11:4], 1'b0, lows, first_low);
      check(first_low == 4, "R1 capture edge", first_low, 4);
      check(lows > 0, "R2 rdy low", lows, 1);
      check(lows == int'(VEC[v][3:0]), "R3 busy length", lows, int'(VEC[v][3:0]));
      sample_run(10);
      for (int k = 0; k < 8; k++) got[k] = s_dat[k];
      check(got == VEC[v][11:4], "R1 R5 byte out", got, VEC[v][11:4]);
      check(s_dat[9] == VEC[v][11], "R5 hold bit 7", s_dat[9], VEC[v][11]);
      check(s_clk[3] == 1'b0 && s_done[9] == 1'b0, "R7 clock follows", s_clk[3], 0);
    end

    // back-to-back writes, third one lands on the transfer edge
    exp_b = 8'hD2;
    send_and_wait(8'h3C, 1'b0, lows, first_low);
    fork
      sample_run(16);
      begin
        bus_write(exp_b, 1'b0);
        bus_write(8'h54, 1'b0);
      end
    join
    for (int k = 0; k < 8; k++) begin
      got[k]   = s_dat[k];
      got_b[k] = s_dat[k + 8];
    end
    check(got == 8'h3C, "R4 first byte", got, 8'h3C);
    check(got_b == exp_b, "R4 second byte no gap", got_b, exp_b);
    check(s_rdy[7] == 1'b0 && s_rdy[8] == 1'b1, "R4 rdy returns at transfer", s_rdy[8], 1);
    lows = 0;
    for (int k = 0; k < 16; k++) if (!s_rdy[k]) lows++;
    check(lows <= 9 && lows > 2, "R4 busy bound", lows, 4);
    check(s_ovr[7] == 1'b0 && s_ovr[8] == 1'b1, "R8 overrun on collision", s_ovr[8], 1);
    #1;
    check(sdat == exp_b[7], "R8 dropped byte absent", sdat, exp_b[7]);
    check(rdy == 1'b1 && ovr == 1'b1, "R8 overrun sticky", ovr, 1);

    // reset again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);

    // final byte
    exp_b = 8'h4B;
    send_and_wait(exp_b, 1'b1, lows, first_low);
    check(lows == 2, "R3 busy on last byte", lows, 2);
    sample_run(12);
    for (int k = 0; k < 7; k++) got[k] = s_dat[k];
    got[7] = 1'b0;
    check(got[6:0] == exp_b[6:0], "R6 seven bits", got[6:0], exp_b[6:0]);
    check(s_done[6] == 1'b0 && s_done[7] == 1'b1, "R6 done timing", s_done[7], 1);
    for (int k = 7; k < 12; k++) begin
      check(s_dat[k] == exp_b[6], "R6 holds bit 6", s_dat[k], exp_b[6]);
      check(s_clk[k] == 1'b1, "R6 clock parked", s_clk[k], 1);
    end
    check(s_clk[2] == 1'b0, "R7 clock toggles before done", s_clk[2], 0);

    // writes after the final byte
    fork
      sample_run(10);
      bus_write(8'h80, 1'b0);
    join
    lows = 0;
    for (int k = 0; k < 10; k++) begin
      if (!s_rdy[k] || s_dat[k] != exp_b[6] || s_ovr[k]) lows++;
    end
    check(lows == 0, "R9 late write ignored", lows, 0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule